// File: doc/BRIEF.md
# Serial Sampling-Converter Frame Front End

This block is the digital side of a multichannel sampling converter's serial port. It acts as a slave on four wires: an active-low select, a serial clock, a data input and a data output with a separate output-enable. All four wires are sampled on the block's own system clock. Each frame lasts sixteen serial clocks and does three jobs at once. It shifts in a sixteen-bit configuration word. It shifts out the tagged result of the conversion started one frame earlier. It also starts a new conversion.

A stub stands in for the analog converter core. For a channel index it returns a fixed ten-bit code. The control register can be written but not read back, and a write takes effect only when the word's top bit is set and the frame runs to its sixteenth falling edge. A frame that ends early is dropped completely: the register write, the channel step and the conversion are all lost. The sequencer picks the channel for each conversion from the channel enables, stepping through them in repeat mode.

The serial side has no back-pressure. The master owns the clock and the frame length, and the block must keep up with every edge. A serial clock phase of at least two system clocks is therefore required. The converter stub answers in the same cycle, so it never stalls a frame.

Top module: `adc_serial_frontend`

## Requirements
- R1: After reset the control register reads all zeros, the output-enable is low, and the reference-select and low-power pins are low.
- R2: A falling edge on `cs_n` turns the output-enable on one system clock later, with the first output bit on `dout`.
- R3: `din` is taken on serial-clock falling edges, most significant bit first. Only the first sixteen falling edges after `cs_n` falls count. Later edges change neither the register nor the output.
- R4: Control bit 15 is the write enable. If it is 1 at the sixteenth edge, bits 14..0 are loaded and bit 15 reads back as 0. If it is 0, the register keeps its value.
- R5: If `cs_n` rises before the sixteenth falling edge, the register is not written, the output-enable drops, and the next frame returns no result (all ones).
- R6: The output word is sent MSB first. Bit 15 is 0, bits 14..12 hold the channel number, bits 11..2 hold the ten-bit straight-binary result, and bits 1..0 are 0.
- R7: The result sent in a frame belongs to the conversion started in the previous complete frame. The first frame after reset sends all ones.
- R8: The output-enable drops one system clock after the sixteenth falling edge, and it is low whenever `cs_n` has been high for a system clock.
- R9: Control bits 13..6 enable channels 0..7 in that order, and bit 14 selects repeat. With repeat clear, the lowest enabled channel is converted. With repeat set, the sequencer moves to the next enabled channel after the current conversion's channel, wrapping around. With no channel enabled, channel 0 is converted.
- R10: While control bit 0 (low power) is set when a frame starts, that frame sends all ones. `low_power` follows bit 0.
- R11: For channel c = {c2,c1,c0}, the stub code is {c2,c1,c0, ~c2,~c1,~c0, c2,c1,c0, ~c2}.
- R12: The channel chosen at the fourteenth edge uses the enables and repeat bit being written in that same frame, if its write bit is set. That choice applies to the conversion started by the next frame, and only if the current frame completes. `ref_ext_sel` follows control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low |
| din | input | 1 | Serial configuration data |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for `dout` (low = high impedance) |
| ref_ext_sel | output | 1 | External reference selected |
| low_power | output | 1 | Partial power-down requested |
| ctrl_word | output | 16 | Current control register contents |

## Verification
Every pin is registered once. The output-enable and each new `dout` bit therefore appear one system clock after the `cs_n` fall or serial-clock fall that causes them, and a register commit shows on `ctrl_word` one clock after the sixteenth fall. The bench changes the serial wires only on falling system-clock edges and holds each serial clock phase for two system clocks. It reads each output bit just before the next serial fall, and reads the output-enable and register two system clocks after the event, so each result is read only after it has settled. Results are checked one whole frame after the frame that started their conversion, against a frame-level model that tracks the pending result, the selected channel and the register.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef struct packed {
    logic start;  // select fell this cycle
    logic mid;    // mux-selection edge of the frame
    logic done;   // last counted serial edge
    logic abort;  // select rose before the last edge
  } frame_evt_t;
endpackage

// File: rtl/sfe_frame_ctl.sv
module sfe_frame_ctl
  import sfe_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int MID_EDGE = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               din,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               dout,
  output logic               dout_oe,
  output frame_evt_t         evt,
  output logic [FRAME_W-1:0] rx_next
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic               cs_q, sclk_q, active;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic               cs_fall, cs_rise, s_fall;

  assign cs_fall = cs_q & ~cs_n;
  assign cs_rise = ~cs_q & cs_n;
  assign s_fall  = sclk_q & ~sclk & ~cs_n & ~cs_fall & active &
                   (cnt < CNT_W'(FRAME_W));
  assign rx_next = {rx_q[FRAME_W-2:0], din};

  assign evt.start = cs_fall;
  assign evt.mid   = s_fall && (cnt == CNT_W'(MID_EDGE - 1));
  assign evt.done  = s_fall && (cnt == CNT_W'(FRAME_W - 1));
  assign evt.abort = cs_rise && active && (cnt != CNT_W'(FRAME_W));

  assign dout = tx_q[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      rx_q    <= '0;
      tx_q    <= '1;
      dout_oe <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_fall) begin
        active  <= 1'b1;
        cnt     <= '0;
        rx_q    <= '0;
        tx_q    <= tx_word;
        dout_oe <= 1'b1;
      end else if (cs_rise) begin
        active  <= 1'b0;
        dout_oe <= 1'b0;
      end else if (s_fall) begin
        rx_q <= rx_next;
        tx_q <= {tx_q[FRAME_W-2:0], 1'b1};
        cnt  <= cnt + 1'b1;
        if (cnt == CNT_W'(FRAME_W - 1)) dout_oe <= 1'b0;
      end
    end
  end

  // R3: the edge counter never passes the frame length
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));
  // R8: select high for a cycle leaves the output undriven
  a_r8_idle_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout_oe);
  // R8: the last counted edge releases the output
  a_r8_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    evt.done |=> !dout_oe);
endmodule

// File: rtl/sfe_chan_seq.sv
module sfe_chan_seq #(
  parameter int NCH  = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]  en,
  input  logic            rpt,
  input  logic [CH_W-1:0] cur,
  output logic [CH_W-1:0] nxt
);
  logic [CH_W-1:0] lowest, after;

  always_comb begin
    lowest = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (en[i]) lowest = CH_W'(i);
    after = lowest;
    for (int k = NCH; k >= 1; k--)
      if (en[(int'(cur) + k) % NCH]) after = CH_W'((int'(cur) + k) % NCH);
    nxt = rpt ? after : lowest;
  end
endmodule

// File: rtl/sfe_conv_stub.sv
module sfe_conv_stub #(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic [CH_W-1:0]  chan,
  output logic [RES_W-1:0] code
);
  // pattern: channel bits, then their complement, alternating, truncated
  for (genvar j = 0; j < RES_W; j++) begin : g_bit
    localparam int SEG = j / CH_W;
    localparam int POS = CH_W - 1 - (j % CH_W);
    if (SEG % 2 == 1) begin : g_inv
      assign code[RES_W-1-j] = ~chan[POS];
    end else begin : g_pass
      assign code[RES_W-1-j] = chan[POS];
    end
  end
endmodule

// File: rtl/adc_serial_frontend.sv
module adc_serial_frontend
  import sfe_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int RES_W   = 10,
  parameter int ADDR_W  = 4,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               din,
  output logic               dout,
  output logic               dout_oe,
  output logic               ref_ext_sel,
  output logic               low_power,
  output logic [FRAME_W-1:0] ctrl_word
);
  localparam int CH_W     = $clog2(NCH);
  localparam int WR_POS   = FRAME_W - 1;
  localparam int RPT_POS  = FRAME_W - 2;
  localparam int EN_TOP   = FRAME_W - 3;
  localparam int REF_POS  = 2;
  localparam int PPD_POS  = 0;
  localparam int MID_EDGE = FRAME_W - 2;
  localparam int TAG_W    = ADDR_W + RES_W;
  localparam int PAD_W    = FRAME_W - TAG_W;

  frame_evt_t         evt;
  logic [FRAME_W-1:0] rx_next, tx_word, mid_word, src_word, ctrl_q;
  logic [CH_W-1:0]    chan_sel, conv_chan, pend_chan, seq_nxt;
  logic [NCH-1:0]     en;
  logic [RES_W-1:0]   code;
  logic [TAG_W-1:0]   res_word;
  logic               res_valid;

  assign tx_word = (res_valid && !ctrl_q[PPD_POS]) ?
                   {res_word, {PAD_W{1'b0}}} : '1;

  sfe_frame_ctl #(.FRAME_W(FRAME_W), .MID_EDGE(MID_EDGE)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .tx_word(tx_word), .dout(dout), .dout_oe(dout_oe),
    .evt(evt), .rx_next(rx_next)
  );

  // at the mux edge the word is partly in: align it to its final positions
  assign mid_word = rx_next << (FRAME_W - MID_EDGE);
  assign src_word = mid_word[WR_POS] ? mid_word : ctrl_q;

  for (genvar i = 0; i < NCH; i++) begin : g_en
    assign en[i] = src_word[EN_TOP-i];
  end

  sfe_chan_seq #(.NCH(NCH)) u_seq (
    .en(en), .rpt(src_word[RPT_POS]), .cur(conv_chan), .nxt(seq_nxt)
  );

  sfe_conv_stub #(.NCH(NCH), .RES_W(RES_W)) u_stub (
    .chan(conv_chan), .code(code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      chan_sel  <= '0;
      conv_chan <= '0;
      pend_chan <= '0;
      res_word  <= '0;
      res_valid <= 1'b0;
    end else begin
      if (evt.start) begin
        conv_chan <= chan_sel;
        res_valid <= 1'b0;
      end
      if (evt.mid) pend_chan <= seq_nxt;
      if (evt.done) begin
        res_valid <= 1'b1;
        res_word  <= {ADDR_W'(conv_chan), code};
        chan_sel  <= pend_chan;
        if (rx_next[WR_POS]) ctrl_q <= {1'b0, rx_next[FRAME_W-2:0]};
      end
    end
  end

  assign ctrl_word   = ctrl_q;
  assign ref_ext_sel = ctrl_q[REF_POS];
  assign low_power   = ctrl_q[PPD_POS];

  // R4: the register moves only on a completed frame
  a_r4_commit_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(evt.done));
  // R5: an aborted frame leaves the register as it was
  a_r5_abort_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    evt.abort |=> $stable(ctrl_q));
  // R7: a result becomes pending only from a completed frame
  a_r7_result_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(evt.done));
endmodule

// File: tb/test_adc_serial_frontend.sv
module test_adc_serial_frontend;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, dout_oe, ref_ext_sel, low_power;
  logic [15:0] ctrl_word;
  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [15:0] m_ctrl = '0;
  logic [13:0] m_res = '0;
  logic        m_valid = 1'b0;
  int          m_next = 0;

  always #2.5 clk = ~clk;

  adc_serial_frontend i_adc_serial_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .ref_ext_sel(ref_ext_sel),
    .low_power(low_power), .ctrl_word(ctrl_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] code_of(input int c);
    logic [2:0] v = 3'(c);
    return {v, ~v, v, ~v[2]};  // R11
  endfunction

  function automatic int next_ch(input logic [15:0] w, input int cur);
    int low = 0;
    logic [7:0] e;
    for (int i = 0; i < 8; i++) e[i] = w[13-i];  // R9 enable mapping
    for (int i = 7; i >= 0; i--) if (e[i]) low = i;
    if (!w[14]) return low;
    for (int k = 1; k <= 8; k++) if (e[(cur + k) % 8]) return (cur + k) % 8;
    return 0;
  endfunction

  // one frame with n serial falling edges; checks against the model
  task automatic run_frame(input logic [15:0] w, input int n, input string req);
    logic [15:0] rx = '1, exp_out;
    int conv;
    exp_out = (m_valid && !m_ctrl[0]) ? {m_res, 2'b00} : 16'hFFFF;
    conv = m_next;
    m_valid = 1'b0;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 oe on after select", 32'(dout_oe), 1);
    for (int i = 0; i < n; i++) begin
      if (i < 16) rx[15-i] = dout;
      sclk = 1'b1;
      din  = (i < 16) ? w[15-i] : 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    if (n >= 16) begin
      chk({req, " output word"}, 32'(rx), 32'(exp_out));
      chk("R8 oe off after last edge", 32'(dout_oe), 0);
      m_next = next_ch(w[15] ? w : m_ctrl, conv);
      if (w[15]) m_ctrl = {1'b0, w[14:0]};
      m_valid = 1'b1;
      m_res = {1'b0, 3'(conv), code_of(conv)};
    end
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 oe off after select rises", 32'(dout_oe), 0);
    chk({req, " control register"}, 32'(ctrl_word), 32'(m_ctrl));
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ctrl after reset", 32'(ctrl_word), 0);
    chk("R1 oe after reset", 32'(dout_oe), 0);
    chk("R1 pins after reset", 32'({ref_ext_sel, low_power}), 0);
  endtask

  task automatic t_first_and_write;
    run_frame(16'h0000, 16, "R7 first frame");
    run_frame(16'h8404, 16, "R4 write ch3 and ref");     // ch3 enable + ext ref
    chk("R12 ref select pin", 32'(ref_ext_sel), 1);
    run_frame(16'h0000, 16, "R6 ch0 result");
    run_frame(16'h0000, 16, "R12 ch3 result");
    chk("R11 ch3 code is 0x1C7", 32'(m_res[9:0]), 32'h1C7);
  endtask

  task automatic t_no_write;
    logic [15:0] keep = m_ctrl;
    run_frame(16'h7FFF, 16, "R4 write bit clear");
    chk("R4 register kept", 32'(ctrl_word), 32'(keep));
  endtask

  task automatic t_short;
    logic [15:0] keep = m_ctrl;
    run_frame(16'h8FC4, 15, "R5 short frame");
    chk("R5 register untouched", 32'(ctrl_word), 32'(keep));
    run_frame(16'h0000, 16, "R5 no result after abort");
  endtask

  task automatic t_repeat;
    run_frame(16'hD280, 16, "R9 repeat write");          // ch1, ch4, ch6
    for (int f = 0; f < 5; f++) run_frame(16'h0000, 16, "R9 repeat step");
    run_frame(16'h9280, 16, "R9 no-repeat write");
    run_frame(16'h0000, 16, "R9 lowest channel");
    run_frame(16'h0000, 16, "R9 lowest channel again");
  endtask

  task automatic t_low_power;
    run_frame(16'h8001, 16, "R10 set low power");
    chk("R10 low_power pin", 32'(low_power), 1);
    run_frame(16'h8000, 16, "R10 ones while low power");
    chk("R10 low_power cleared", 32'(low_power), 0);
    run_frame(16'h0000, 16, "R9 no channel gives ch0");
    run_frame(16'h0000, 16, "R9 ch0 result");
  endtask

  task automatic t_extra_edges;
    run_frame(16'h8A00, 19, "R3 extra edges ignored");  // ch2,ch4 enables
    chk("R3 register from first 16 bits", 32'(ctrl_word), 32'h0A00);
    run_frame(16'h0000, 16, "R3 frame after extras");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_first_and_write();
    t_no_write();
    t_short();
    t_repeat();
    t_low_power();
    t_extra_edges();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule